// File: doc/BRIEF.md
# Receive Timestamp Upper-Bit Reconstructor

This block restores the full 55-bit value of a receive timestamp when only its low 32 bits reach the user side. A free-running system timer, carrying all 55 bits, is sampled in the same cycle as the truncated value. The true capture time can only lie a short receive-path latency before that reference. That gap is tiny next to the 2^32-tick span of the low field. So the block picks the high 23 bits that put the result at, or just before, the reference.

When the reference low field is numerically at or above the truncated value, no rollover has happened between capture and sampling, and the reference's high bits are copied. When the reference low field is below the truncated value, the low field wrapped in between, and the high bits are taken as the reference's high bits minus one, modulo 2^23. Timestamps flagged as belonging to short packets are discarded. The result is registered, so it appears one clock after the input.

Top module: `ts_upper_rebuild`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `out_valid` becomes 0 and `out_ts` becomes all zeros.
- R2: An input with `in_valid`=1 and `in_short`=0 at a rising edge produces `out_valid`=1 after exactly that edge (one cycle latency), including on back-to-back cycles.
- R3: An input with `in_valid`=1 and `in_short`=1 is ignored: `out_valid` is 0 after that edge and `out_ts` keeps its previous value.
- R4: When `ref_timer[31:0]` >= `in_ts_low` (equality included), the accepted result's bits [54:32] equal `ref_timer[54:32]`.
- R5: When `ref_timer[31:0]` < `in_ts_low`, the accepted result's bits [54:32] equal `ref_timer[54:32]` minus one.
- R6: In the R5 case with `ref_timer[54:32]` = 0, the result's bits [54:32] wrap to all ones (0x7FFFFF).
- R7: The accepted result's bits [31:0] equal `in_ts_low`.
- R8: After an edge with `in_valid`=0, `out_valid` is 0 and `out_ts` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Truncated timestamp present this cycle |
| in_short | input | 1 | Timestamp belongs to a short packet; discard it |
| in_ts_low | input | 32 | Low 32 bits of the captured timestamp |
| ref_timer | input | 55 | Full-width system timer, sampled with `in_valid` |
| out_valid | output | 1 | Rebuilt timestamp valid, one cycle after input |
| out_ts | output | 55 | Rebuilt full-width timestamp |

## Verification
The block has no internal state beyond the output register. A wrong rollover decision therefore shows up at the ports on the very next clock, as a high field off by exactly one. This happens either on the equality boundary or when the low field has wrapped. The vectors cover both sides of that comparison, the equality case and the all-zero high field that must wrap. A short-packet or idle cycle that wrongly touches the output register is visible on the following clock. It shows as a raised `out_valid` or a changed `out_ts`.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
// Package: shared widths for the timestamp rebuild path.
// Assumes the full stamp is split into a delivered low field and a
// dropped high field whose widths add up to the full width.
package rb_pkg;
    localparam int unsigned RB_FULL_W = 55;
    localparam int unsigned RB_LOW_W  = 32;
    localparam int unsigned RB_HIGH_W = RB_FULL_W - RB_LOW_W;

    // Decision taken by the comparator for one input.
    typedef enum logic [0:0] {
        EPOCH_SAME = 1'b0,   // low field did not wrap since capture
        EPOCH_PREV = 1'b1    // low field wrapped; step back one epoch
    } epoch_sel_e;
endpackage

// File: rtl/rb_wrap_detect.sv
`timescale 1ns/1ps
// Module: rb_wrap_detect
// Decides whether the low field of the reference wrapped between the
// capture and the reference sample. Assumes the capture precedes the
// reference by far less than one low-field period, so a reference low
// field below the captured low field can only mean a wrap.
module rb_wrap_detect
    import rb_pkg::*;
#(
    parameter int unsigned LOW_W = RB_LOW_W
) (
    input  logic [LOW_W-1:0] cap_low,
    input  logic [LOW_W-1:0] ref_low,
    output epoch_sel_e       sel
);
    // Purpose: an unsigned compare; equality counts as no wrap.
    always_comb begin
        sel = (ref_low >= cap_low) ? EPOCH_SAME : EPOCH_PREV;
    end
endmodule

// File: rtl/rb_epoch_pick.sv
`timescale 1ns/1ps
// Module: rb_epoch_pick
// Produces the high field of the rebuilt stamp from the reference's
// high field and the wrap decision. Assumes modular arithmetic on the
// high field, so an all-zero epoch steps back to all ones.
module rb_epoch_pick
    import rb_pkg::*;
#(
    parameter int unsigned HIGH_W = RB_HIGH_W
) (
    input  logic [HIGH_W-1:0] ref_high,
    input  epoch_sel_e        sel,
    output logic [HIGH_W-1:0] high_out
);
    logic [HIGH_W-1:0] prev_high;

    // Purpose: form the preceding epoch, wrapping modulo 2^HIGH_W.
    always_comb begin
        prev_high = ref_high - {{(HIGH_W-1){1'b0}}, 1'b1};
    end

    // Purpose: pick between current and preceding epoch.
    always_comb begin
        unique case (sel)
            EPOCH_SAME: high_out = ref_high;
            EPOCH_PREV: high_out = prev_high;
            default:    high_out = ref_high;
        endcase
    end
endmodule

// File: rtl/rb_out_stage.sv
`timescale 1ns/1ps
// Module: rb_out_stage
// Output register for the rebuilt stamp. Loads only on an accepted
// input and otherwise holds. The valid flag follows the accept by one
// cycle. Assumes a synchronous active-low reset.
module rb_out_stage #(
    parameter int unsigned FULL_W = rb_pkg::RB_FULL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_short,
    input  logic [FULL_W-1:0] next_ts,
    output logic              out_valid,
    output logic [FULL_W-1:0] out_ts
);
    logic accept;

    // Purpose: a timestamp is taken only when present and not short.
    always_comb begin
        accept = in_valid & ~in_short;
    end

    // Purpose: valid flag register, one cycle behind the accept.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= accept;
    end

    // Purpose: data register, loaded on accept and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_ts <= '0;
        else if (accept) out_ts <= next_ts;
    end

    // R2: an accepted input raises valid on the next cycle.
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_short) |=> out_valid);

    // R3: a short-packet stamp leaves valid low and the data untouched.
    assert_short_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_short) |=> (!out_valid && $stable(out_ts)));

    // R8: an idle cycle leaves valid low and the data untouched.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_ts)));
endmodule

// File: rtl/ts_upper_rebuild.sv
`timescale 1ns/1ps
// Module: ts_upper_rebuild (top)
// Rebuilds a full-width receive timestamp from its delivered low field
// and a full-width reference timer sampled in the same cycle. Assumes
// the capture precedes the reference by much less than one low-field
// period, and picks the nearest value at or before the reference.
// Short-packet stamps are dropped. One cycle of latency.
module ts_upper_rebuild
    import rb_pkg::*;
#(
    parameter int unsigned FULL_W = RB_FULL_W,
    parameter int unsigned LOW_W  = RB_LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_short,
    input  logic [LOW_W-1:0]  in_ts_low,
    input  logic [FULL_W-1:0] ref_timer,
    output logic              out_valid,
    output logic [FULL_W-1:0] out_ts
);
    localparam int unsigned HIGH_W = FULL_W - LOW_W;

    logic [LOW_W-1:0]  ref_low;
    logic [HIGH_W-1:0] ref_high;
    logic [HIGH_W-1:0] high_pick;
    logic [FULL_W-1:0] rebuilt;
    epoch_sel_e        sel;

    // Purpose: split the reference timer into its two fields.
    always_comb begin
        ref_low  = ref_timer[LOW_W-1:0];
        ref_high = ref_timer[FULL_W-1:LOW_W];
    end

    rb_wrap_detect #(.LOW_W(LOW_W)) i_wrap (
        .cap_low (in_ts_low),
        .ref_low (ref_low),
        .sel     (sel)
    );

    rb_epoch_pick #(.HIGH_W(HIGH_W)) i_epoch (
        .ref_high (ref_high),
        .sel      (sel),
        .high_out (high_pick)
    );

    // Purpose: join the chosen epoch with the delivered low field.
    always_comb begin
        rebuilt = {high_pick, in_ts_low};
    end

    rb_out_stage #(.FULL_W(FULL_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_short  (in_short),
        .next_ts   (rebuilt),
        .out_valid (out_valid),
        .out_ts    (out_ts)
    );

    // R7: the low field passes through unchanged.
    assert_low_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_short) |=> (out_ts[LOW_W-1:0] == $past(in_ts_low)));

    // R4: no wrap, so the reference epoch is kept.
    assert_same_epoch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_short && (ref_timer[LOW_W-1:0] >= in_ts_low))
        |=> (out_ts[FULL_W-1:LOW_W] == $past(ref_timer[FULL_W-1:LOW_W])));

    // R5 and R6: a wrap steps the epoch back by one, modulo its width.
    assert_prev_epoch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_short && (ref_timer[LOW_W-1:0] < in_ts_low))
        |=> ((out_ts[FULL_W-1:LOW_W] + {{(HIGH_W-1){1'b0}}, 1'b1})
             == $past(ref_timer[FULL_W-1:LOW_W])));

    // R1: while reset is asserted the outputs clear on the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (out_ts == '0)));
endmodule

// File: tb/test_ts_upper_rebuild.sv
`timescale 1ns/1ps
module test_ts_upper_rebuild;
    localparam int NV = 8;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_short;
    logic [31:0] in_ts_low;
    logic [54:0] ref_timer;
    logic        out_valid;
    logic [54:0] out_ts;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(TCLK/2) clk = ~clk;

    ts_upper_rebuild i_ts_upper_rebuild (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_short(in_short),
        .in_ts_low(in_ts_low), .ref_timer(ref_timer),
        .out_valid(out_valid), .out_ts(out_ts)
    );

    // Vector table: short flag, truncated low field, reference, expected
    // valid, expected output (a short vector expects the previous output).
    localparam logic        V_SHORT [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
    localparam logic [31:0] V_TS    [NV] = '{
        32'h0000_1000, 32'h0000_2000, 32'hFFFF_FFF0, 32'hFFFF_FF00,
        32'h0000_1234, 32'hDEAD_BEEF, 32'h8000_0000, 32'h0000_0000};
    localparam logic [54:0] V_REF   [NV] = '{
        {23'h012345, 32'h0000_1010}, {23'h000007, 32'h0000_2000},
        {23'h000100, 32'h0000_0010}, {23'h000000, 32'h0000_0005},
        {23'h000001, 32'h0000_2000}, {23'h7FFFFF, 32'hDEAD_BEF0},
        {23'h000040, 32'h7FFF_FFFF}, {23'h000000, 32'h0000_0000}};
    localparam logic [54:0] V_EXP   [NV] = '{
        {23'h012345, 32'h0000_1000}, {23'h000007, 32'h0000_2000},
        {23'h0000FF, 32'hFFFF_FFF0}, {23'h7FFFFF, 32'hFFFF_FF00},
        {23'h7FFFFF, 32'hFFFF_FF00}, {23'h7FFFFF, 32'hDEAD_BEEF},
        {23'h00003F, 32'h8000_0000}, {23'h000000, 32'h0000_0000}};
    localparam string V_REQ [NV] = '{"R4", "R4", "R5", "R6", "R3", "R7", "R5", "R4"};

    task automatic check(input string req, input logic [54:0] act, input logic [54:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic [31:0] t, input logic [54:0] r);
        @(negedge clk);
        in_valid = v; in_short = s; in_ts_low = t; ref_timer = r;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(TCLK * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [54:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_short = 1'b0;
        in_ts_low = '0; ref_timer = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {54'd0, out_valid}, 55'd0);
        check("R1 data", out_ts, 55'd0);
        rst_n = 1'b1;

        // Table walk: each vector is applied for one cycle then idled.
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, V_SHORT[i], V_TS[i], V_REF[i]);
            drive(1'b0, 1'b0, 32'h5555_AAAA, {23'h3, 32'h0});
            check({V_REQ[i], " valid R2"}, {54'd0, out_valid}, {54'd0, ~V_SHORT[i]});
            check(V_REQ[i], out_ts, V_EXP[i]);
            drive(1'b0, 1'b0, 32'h0, 55'd0);
            check("R8 idle valid", {54'd0, out_valid}, 55'd0);
            check("R8 idle hold", out_ts, V_EXP[i]);
        end

        // Back-to-back accepts, one result per cycle (R2).
        drive(1'b1, 1'b0, 32'h0000_0010, {23'h000022, 32'h0000_0020});
        drive(1'b1, 1'b0, 32'h0000_0030, {23'h000022, 32'h0000_0020});
        check("R2 b2b first valid", {54'd0, out_valid}, 55'd1);
        check("R4 b2b first", out_ts, {23'h000022, 32'h0000_0010});
        drive(1'b0, 1'b0, 32'h0, 55'd0);
        check("R2 b2b second valid", {54'd0, out_valid}, 55'd1);
        check("R5 b2b second", out_ts, {23'h000021, 32'h0000_0030});
        held = out_ts;

        // Short stamp whose rebuild would differ: output must hold (R3).
        drive(1'b1, 1'b1, 32'h0000_0001, {23'h000500, 32'h0000_0002});
        drive(1'b0, 1'b0, 32'h0, 55'd0);
        check("R3 short valid", {54'd0, out_valid}, 55'd0);
        check("R3 short hold", out_ts, held);

        // Reset in mid-run clears a loaded result (R1).
        drive(1'b1, 1'b0, 32'h0000_0100, {23'h000777, 32'h0000_0200});
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid valid", {54'd0, out_valid}, 55'd0);
        check("R1 mid data", out_ts, 55'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule